// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic unit of a small accumulator-based processor. It works on either an 8-bit accumulator or a 16-bit accumulator pair. It adds, adds with carry, subtracts, subtracts with borrow, negates, clears, increments, decrements and passes a load value through. It also steps a 16-bit index register up or down. For each of these it works out the next value of an eight-bit condition flag register.

Each operation class touches only its own set of flags. Arithmetic sets carry, overflow, sign, zero and half-carry. Clear and load write fixed patterns into some flags. An index step touches only the zero flag. There are also dedicated operations that:

- set or clear the carry, overflow and interrupt-mask flags one at a time;
- copy the low byte of operand A into the whole flag register;
- return the flag register as the result.

The result and the next flags are combinational. The flag register itself takes the next value on a rising clock edge while its write enable is high. Instruction decode, memory access and interrupt handling sit outside the block.

Top module: `alu_ccr_unit`

## Requirements
- R1: Operation code 0 (add) gives A+B and code 1 (add with carry) gives A+B+C, where C is the registered carry flag. In 8-bit mode (wide=0) only the low bytes are used, and result bits 15:8 are 0. In 16-bit mode (wide=1) all 16 bits are used. The carry flag is set when the unsigned sum exceeds 255 (8-bit) or 65535 (16-bit).
- R2: Operation code 2 (subtract) gives A−B, code 3 (subtract with borrow) gives A−B−C, and code 4 (negate) gives 0−A, each in the selected width. The carry flag is set exactly when the true difference is below zero.
- R3: For codes 0 to 4, code 6 and code 7, the overflow flag is set exactly when the signed result leaves the range −2^(k−1) to 2^(k−1)−1, where k is 8 or 16.
- R4: The flag register bits are, from bit 7 down to bit 0: stop-disable, X-mask, half-carry, I-mask, negative, zero, overflow, carry. Every operation that updates the negative flag copies bit 7 (8-bit) or bit 15 (16-bit) of the result into it. Every operation that updates the zero flag sets it exactly when the result is zero in the selected width.
- R5: The half-carry flag takes the carry out of bit 3 on codes 0 and 1 in 8-bit mode. Every other operation leaves it unchanged.
- R6: Code 5 (clear) gives a result of 0 and forces negative=0, zero=1, overflow=0 and carry=0.
- R7: Code 6 (increment) gives A+1 and code 7 (decrement) gives A−1 in the selected width. Both update negative, zero and overflow, and leave carry unchanged.
- R8: Code 8 (load) passes A through in the selected width. It updates negative and zero, clears overflow and leaves carry unchanged.
- R9: Code 9 (index increment) and code 10 (index decrement) always work on all 16 bits, whatever the value of wide. They update only the zero flag and leave every other flag unchanged.
- R10: Codes 11 and 12 set and clear carry, codes 13 and 14 set and clear overflow, and codes 15 and 16 set and clear the I-mask. No other flag changes, and the result equals A.
- R11: Code 17 writes A[7:0] into all eight flags and returns A. Code 18 returns the flag register, zero-extended, and changes no flag.
- R12: Synchronous reset clears the flag register to 0x00. The register takes the next-flag value on a rising edge only while ccr_we is 1, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 5 | Operation code |
| wide | input | 1 | 1 selects 16-bit operands, 0 selects 8-bit |
| opa | input | 16 | Operand A (accumulator or index value) |
| opb | input | 16 | Operand B |
| ccr_we | input | 1 | Flag register write enable |
| result | output | 16 | Combinational result |
| flags_next | output | 8 | Combinational next flag value |
| ccr_q | output | 8 | Registered flag value |

## Verification
The bench sweeps every pair of 8-bit operands through add, add with carry, subtract and subtract with borrow, so every carry, borrow, overflow and half-carry boundary is exercised.

- A design that takes overflow from the wrong carry pair, or that gets the borrow polarity wrong, fails at the 0x7F/0x80 boundaries and at 0x00−0x01.
- A design that picks the wrong sign bit for the width fails on the 16-bit corners 0x7FFF+1, 0xFFFF+1 and 0x8000−1.

The bench also starts the flag register from opposite bit patterns and checks that clear, load, increment and index steps leave alone the flags they must not touch. A design that updated carry on increment, or negative on an index step, would show up there.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int OP_W   = 5;
    localparam int CCR_W  = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADC   = 5'd1,
        OP_SUB   = 5'd2,
        OP_SBC   = 5'd3,
        OP_NEG   = 5'd4,
        OP_CLR   = 5'd5,
        OP_INC   = 5'd6,
        OP_DEC   = 5'd7,
        OP_LOAD  = 5'd8,
        OP_IXINC = 5'd9,
        OP_IXDEC = 5'd10,
        OP_SETC  = 5'd11,
        OP_CLRC  = 5'd12,
        OP_SETV  = 5'd13,
        OP_CLRV  = 5'd14,
        OP_SETI  = 5'd15,
        OP_CLRI  = 5'd16,
        OP_A2CC  = 5'd17,
        OP_CC2A  = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] y;
        logic              cin;
        logic              wide;
    } addsub_ctl_t;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_ccr_pkg::*;
(
    input  alu_op_e           op,
    input  logic              wide,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              carry_flag,
    output addsub_ctl_t       ctl
);

    always_comb begin
        ctl.x    = opa;
        ctl.y    = '0;
        ctl.cin  = 1'b0;
        ctl.wide = wide;
        unique case (op)
            OP_ADD: begin
                ctl.y = opb;
            end
            OP_ADC: begin
                ctl.y   = opb;
                ctl.cin = carry_flag;
            end
            OP_SUB: begin
                ctl.y   = ~opb;
                ctl.cin = 1'b1;
            end
            OP_SBC: begin
                ctl.y   = ~opb;
                ctl.cin = ~carry_flag;
            end
            OP_NEG: begin
                ctl.x   = '0;
                ctl.y   = ~opa;
                ctl.cin = 1'b1;
            end
            OP_CLR: begin
                ctl.x = '0;
            end
            OP_INC: begin
                ctl.cin = 1'b1;
            end
            OP_DEC: begin
                ctl.y = '1;
            end
            OP_IXINC: begin
                ctl.cin  = 1'b1;
                ctl.wide = 1'b1;
            end
            OP_IXDEC: begin
                ctl.y    = '1;
                ctl.wide = 1'b1;
            end
            default: begin
                ctl.x = opa;
            end
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0] x,
    input  logic [WORD_W-1:0] y,
    input  logic              cin,
    input  logic              wide,
    output logic [WORD_W-1:0] sum,
    output logic              cout,
    output logic              c_into_msb,
    output logic              half_c
);

    localparam int NIB_W = BYTE_W / 2;

    logic [WORD_W:0]   full_w;
    logic [WORD_W-1:0] low_w;
    logic [BYTE_W:0]   full_b;
    logic [BYTE_W-1:0] low_b;
    logic [NIB_W:0]    nib;

    always_comb begin
        full_w = {1'b0, x} + {1'b0, y} + (WORD_W+1)'(cin);
        low_w  = {1'b0, x[WORD_W-2:0]} + {1'b0, y[WORD_W-2:0]} + WORD_W'(cin);
        full_b = {1'b0, x[BYTE_W-1:0]} + {1'b0, y[BYTE_W-1:0]} + (BYTE_W+1)'(cin);
        low_b  = {1'b0, x[BYTE_W-2:0]} + {1'b0, y[BYTE_W-2:0]} + BYTE_W'(cin);
        nib    = {1'b0, x[NIB_W-1:0]} + {1'b0, y[NIB_W-1:0]} + (NIB_W+1)'(cin);
    end

    assign sum        = full_w[WORD_W-1:0];
    assign cout       = wide ? full_w[WORD_W] : full_b[BYTE_W];
    assign c_into_msb = wide ? low_w[WORD_W-1] : low_b[BYTE_W-1];
    assign half_c     = nib[NIB_W];

endmodule

// File: rtl/alu_flag_update.sv
module alu_flag_update
    import alu_ccr_pkg::*;
(
    input  alu_op_e           op,
    input  logic              wide,
    input  logic [WORD_W-1:0] res,
    input  logic              cout,
    input  logic              c_into_msb,
    input  logic              half_c,
    input  logic [WORD_W-1:0] opa,
    input  ccr_t              cc,
    output ccr_t              nxt
);

    logic neg_bit;
    logic zero_bit;
    logic ovf_bit;

    always_comb begin
        neg_bit  = wide ? res[WORD_W-1] : res[BYTE_W-1];
        zero_bit = wide ? (res == '0) : (res[BYTE_W-1:0] == '0);
        ovf_bit  = cout ^ c_into_msb;
    end

    always_comb begin
        nxt = cc;
        unique case (op)
            OP_ADD, OP_ADC: begin
                nxt.n = neg_bit;
                nxt.z = zero_bit;
                nxt.v = ovf_bit;
                nxt.c = cout;
                if (!wide) begin
                    nxt.h = half_c;
                end
            end
            OP_SUB, OP_SBC, OP_NEG: begin
                nxt.n = neg_bit;
                nxt.z = zero_bit;
                nxt.v = ovf_bit;
                nxt.c = ~cout;
            end
            OP_CLR: begin
                nxt.n = 1'b0;
                nxt.z = 1'b1;
                nxt.v = 1'b0;
                nxt.c = 1'b0;
            end
            OP_INC, OP_DEC: begin
                nxt.n = neg_bit;
                nxt.z = zero_bit;
                nxt.v = ovf_bit;
            end
            OP_LOAD: begin
                nxt.n = neg_bit;
                nxt.z = zero_bit;
                nxt.v = 1'b0;
            end
            OP_IXINC, OP_IXDEC: begin
                nxt.z = zero_bit;
            end
            OP_SETC: nxt.c = 1'b1;
            OP_CLRC: nxt.c = 1'b0;
            OP_SETV: nxt.v = 1'b1;
            OP_CLRV: nxt.v = 1'b0;
            OP_SETI: nxt.i = 1'b1;
            OP_CLRI: nxt.i = 1'b0;
            OP_A2CC: nxt   = ccr_t'(opa[CCR_W-1:0]);
            default: nxt   = cc;
        endcase
    end

endmodule

// File: rtl/alu_ccr_reg.sv
module alu_ccr_reg
    import alu_ccr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  ccr_t d,
    output ccr_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/alu_ccr_unit.sv
module alu_ccr_unit
    import alu_ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op,
    input  logic              wide,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              ccr_we,
    output logic [WORD_W-1:0] result,
    output logic [CCR_W-1:0]  flags_next,
    output logic [CCR_W-1:0]  ccr_q
);

    alu_op_e           op_e;
    addsub_ctl_t       ctl;
    ccr_t              cc_cur;
    ccr_t              cc_nxt;
    logic [WORD_W-1:0] sum;
    logic              cout;
    logic              c_msb;
    logic              half_c;
    logic [WORD_W-1:0] res;

    assign op_e = alu_op_e'(op);

    alu_operand_sel u_sel (
        .op         (op_e),
        .wide       (wide),
        .opa        (opa),
        .opb        (opb),
        .carry_flag (cc_cur.c),
        .ctl        (ctl)
    );

    alu_addsub #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_add (
        .x          (ctl.x),
        .y          (ctl.y),
        .cin        (ctl.cin),
        .wide       (ctl.wide),
        .sum        (sum),
        .cout       (cout),
        .c_into_msb (c_msb),
        .half_c     (half_c)
    );

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG,
            OP_CLR, OP_INC, OP_DEC, OP_LOAD: begin
                res = ctl.wide ? sum : {{(WORD_W-BYTE_W){1'b0}}, sum[BYTE_W-1:0]};
            end
            OP_IXINC, OP_IXDEC: res = sum;
            OP_CC2A:            res = {{(WORD_W-CCR_W){1'b0}}, cc_cur};
            default:            res = opa;
        endcase
    end

    alu_flag_update u_flags (
        .op         (op_e),
        .wide       (ctl.wide),
        .res        (res),
        .cout       (cout),
        .c_into_msb (c_msb),
        .half_c     (half_c),
        .opa        (opa),
        .cc         (cc_cur),
        .nxt        (cc_nxt)
    );

    alu_ccr_reg u_ccr (
        .clk (clk),
        .rst (rst),
        .we  (ccr_we),
        .d   (cc_nxt),
        .q   (cc_cur)
    );

    assign result     = res;
    assign flags_next = cc_nxt;
    assign ccr_q      = cc_cur;

endmodule

// File: rtl/alu_ccr_unit_chk.sv
module alu_ccr_unit_chk
    import alu_ccr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op,
    input logic              wide,
    input logic [WORD_W-1:0] opa,
    input logic              ccr_we,
    input logic [WORD_W-1:0] result,
    input logic [CCR_W-1:0]  flags_next,
    input logic [CCR_W-1:0]  ccr_q
);

    assert_ccr_reset_R12: assert property (@(posedge clk)
        rst |=> (ccr_q == 8'h00));

    assert_ccr_write_R12: assert property (@(posedge clk) disable iff (rst)
        ccr_we |=> (ccr_q == $past(flags_next)));

    assert_ccr_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!ccr_we && !rst) |=> $stable(ccr_q));

    assert_clear_pattern_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR) |-> (result == '0 && flags_next[3:0] == 4'b0100));

    assert_index_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IXINC || op == OP_IXDEC) |->
        (flags_next[7:3] == ccr_q[7:3] && flags_next[1:0] == ccr_q[1:0]));

    assert_load_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |-> (!flags_next[1] && flags_next[0] == ccr_q[0]));

    assert_zero_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (op <= OP_LOAD && op != OP_NEG && !wide) |->
        (flags_next[2] == (result[7:0] == 8'h00)));

    assert_upper_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (op <= OP_LOAD && !wide) |-> (result[15:8] == 8'h00));

    assert_tpa_no_change_R11: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CC2A) |-> (flags_next == ccr_q && result[7:0] == ccr_q));

endmodule

bind alu_ccr_unit alu_ccr_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .wide       (wide),
    .opa        (opa),
    .ccr_we     (ccr_we),
    .result     (result),
    .flags_next (flags_next),
    .ccr_q      (ccr_q)
);

// File: tb/alu_ccr_unit_tb.sv
module alu_ccr_unit_tb;
    import alu_ccr_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  op;
    logic        wide;
    logic [15:0] opa;
    logic [15:0] opb;
    logic        ccr_we;
    logic [15:0] result;
    logic [7:0]  flags_next;
    logic [7:0]  ccr_q;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] cc_model;

    always #2.5 clk = ~clk;

    alu_ccr_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .wide       (wide),
        .opa        (opa),
        .opb        (opb),
        .ccr_we     (ccr_we),
        .result     (result),
        .flags_next (flags_next),
        .ccr_q      (ccr_q)
    );

    function automatic longint sx(longint v, int w);
        return (v >= (64'sd1 <<< (w-1))) ? v - (64'sd1 <<< w) : v;
    endfunction

    function automatic logic [23:0] model(logic [4:0] o, logic w8, logic [15:0] a,
                                          logic [15:0] b, logic [7:0] cc);
        int w;
        longint m, ua, ub, r, sr, ci, smax, smin;
        logic [7:0] f;
        logic [15:0] res;
        logic upd_nz;
        w = (o == OP_IXINC || o == OP_IXDEC || w8) ? 16 : 8;
        m = (64'sd1 <<< w) - 1;
        smax = (64'sd1 <<< (w-1)) - 1;
        smin = -(64'sd1 <<< (w-1));
        ua = longint'(a) & m;
        ub = longint'(b) & m;
        f = cc;
        res = a;
        upd_nz = 1'b0;
        r = 0;
        case (o)
            OP_ADD, OP_ADC: begin
                ci = (o == OP_ADC) ? longint'(cc[0]) : 0;
                r = ua + ub + ci;
                sr = sx(ua, w) + sx(ub, w) + ci;
                f[0] = (r > m);
                f[1] = (sr > smax) || (sr < smin);
                if (w == 8) f[5] = (((ua & 15) + (ub & 15) + ci) > 15);
                upd_nz = 1'b1;
            end
            OP_SUB, OP_SBC: begin
                ci = (o == OP_SBC) ? longint'(cc[0]) : 0;
                r = ua - ub - ci;
                sr = sx(ua, w) - sx(ub, w) - ci;
                f[0] = (r < 0);
                f[1] = (sr > smax) || (sr < smin);
                upd_nz = 1'b1;
            end
            OP_NEG: begin
                r = 0 - ua;
                sr = 0 - sx(ua, w);
                f[0] = (r < 0);
                f[1] = (sr > smax) || (sr < smin);
                upd_nz = 1'b1;
            end
            OP_CLR: begin
                r = 0;
                f[3:0] = 4'b0100;
            end
            OP_INC, OP_DEC: begin
                r = (o == OP_INC) ? ua + 1 : ua - 1;
                sr = (o == OP_INC) ? sx(ua, w) + 1 : sx(ua, w) - 1;
                f[1] = (sr > smax) || (sr < smin);
                upd_nz = 1'b1;
            end
            OP_LOAD: begin
                r = ua;
                f[1] = 1'b0;
                upd_nz = 1'b1;
            end
            OP_IXINC, OP_IXDEC: begin
                r = (o == OP_IXINC) ? ua + 1 : ua - 1;
                f[2] = ((r & m) == 0);
            end
            OP_SETC: f[0] = 1'b1;
            OP_CLRC: f[0] = 1'b0;
            OP_SETV: f[1] = 1'b1;
            OP_CLRV: f[1] = 1'b0;
            OP_SETI: f[4] = 1'b1;
            OP_CLRI: f[4] = 1'b0;
            OP_A2CC: f = a[7:0];
            default: ;
        endcase
        if (o <= OP_IXDEC) res = 16'(r & m);
        if (o == OP_CC2A) res = {8'h00, cc};
        if (upd_nz) begin
            f[3] = res[w-1];
            f[2] = (res == 16'h0000);
        end
        return {res, f};
    endfunction

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic vec(string req, logic [4:0] o, logic w8, logic [15:0] a, logic [15:0] b);
        op = o; wide = w8; opa = a; opb = b;
        #1;
        chk(req, {result, flags_next}, model(o, w8, a, b, cc_model));
    endtask

    task automatic set_cc(logic [7:0] v);
        @(negedge clk);
        op = OP_A2CC; opa = {8'h00, v}; ccr_we = 1'b1;
        @(negedge clk);
        ccr_we = 1'b0;
        cc_model = v;
        chk("R11 copy A into flags", {16'h0, ccr_q}, {16'h0, v});
    endtask

    task automatic reg_op(string req, logic [4:0] o, logic we);
        logic [7:0] exp;
        @(negedge clk);
        op = o; opa = 16'h3C00; ccr_we = we;
        exp = model(o, 1'b0, 16'h3C00, 16'h0, cc_model);
        @(negedge clk);
        ccr_we = 1'b0;
        if (we) cc_model = exp;
        chk(req, {16'h0, ccr_q}, {16'h0, cc_model});
    endtask

    initial begin
        #900000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        rst = 1'b1; op = OP_ADD; wide = 1'b0; opa = '0; opb = '0; ccr_we = 1'b0;
        cc_model = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R12 reset value", {16'h0, ccr_q}, 24'h0);

        // R1 R3 R4 R5: full 8-bit add sweep, carry flag clear then set
        set_cc(8'h00);
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                vec("R1 R3 R4 R5 add8", OP_ADD, 1'b0, 16'(a), 16'(b));
        set_cc(8'hD1);
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                vec("R1 R3 R5 adc8", OP_ADC, 1'b0, 16'(a) | 16'hAB00, 16'(b));

        // R2 R3: full 8-bit subtract sweep
        set_cc(8'h20);
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                vec("R2 R3 sub8", OP_SUB, 1'b0, 16'(a), 16'(b));
        set_cc(8'h01);
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                vec("R2 R3 sbc8", OP_SBC, 1'b0, 16'(a), 16'(b) | 16'h5500);

        // R2 R6 R7 R8: single-operand ops from opposite flag patterns
        for (int p = 0; p < 2; p++) begin
            set_cc(p == 0 ? 8'hFF : 8'h00);
            for (int a = 0; a < 256; a++) begin
                vec("R2 neg8", OP_NEG, 1'b0, 16'(a), 16'h0);
                vec("R6 clear", OP_CLR, 1'b0, 16'(a), 16'h0);
                vec("R7 inc8", OP_INC, 1'b0, 16'(a), 16'h0);
                vec("R7 dec8", OP_DEC, 1'b0, 16'(a), 16'h0);
                vec("R8 load8", OP_LOAD, 1'b0, 16'(a), 16'h0);
            end
        end

        // R1 R2 R3 R4: 16-bit corners and pseudo-random vectors
        for (int p = 0; p < 2; p++) begin
            set_cc(p == 0 ? 8'h00 : 8'h01);
            vec("R1 R3 add16 0x7FFF+1", OP_ADD, 1'b1, 16'h7FFF, 16'h0001);
            vec("R1 R4 add16 0xFFFF+1", OP_ADD, 1'b1, 16'hFFFF, 16'h0001);
            vec("R1 adc16 carry in", OP_ADC, 1'b1, 16'hFFFF, 16'h0000);
            vec("R2 R3 sub16 0x8000-1", OP_SUB, 1'b1, 16'h8000, 16'h0001);
            vec("R2 sub16 0-1", OP_SUB, 1'b1, 16'h0000, 16'h0001);
            vec("R2 sbc16 borrow", OP_SBC, 1'b1, 16'h0000, 16'h0000);
            vec("R2 R3 neg16 0x8000", OP_NEG, 1'b1, 16'h8000, 16'h0);
            vec("R7 inc16 0x7FFF", OP_INC, 1'b1, 16'h7FFF, 16'h0);
            vec("R8 load16 0x8000", OP_LOAD, 1'b1, 16'h8000, 16'h0);
            lf = 16'hACE1;
            for (int k = 0; k < 400; k++) begin
                logic [15:0] a16;
                a16 = lf;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                vec("R1 R3 R4 add16", OP_ADD, 1'b1, a16, lf);
                vec("R1 adc16", OP_ADC, 1'b1, a16, lf);
                vec("R2 R3 sub16", OP_SUB, 1'b1, a16, lf);
                vec("R2 sbc16", OP_SBC, 1'b1, a16, lf);
            end
        end

        // R9: index steps ignore wide and touch only zero
        for (int p = 0; p < 2; p++) begin
            set_cc(p == 0 ? 8'hFB : 8'h04);
            vec("R9 index inc wrap", OP_IXINC, 1'b0, 16'hFFFF, 16'h0);
            vec("R9 index inc carry byte", OP_IXINC, 1'b0, 16'h00FF, 16'h0);
            vec("R9 index dec to zero", OP_IXDEC, 1'b0, 16'h0001, 16'h0);
            vec("R9 index dec wrap", OP_IXDEC, 1'b1, 16'h0000, 16'h0);
            vec("R9 index inc sign", OP_IXINC, 1'b1, 16'h7FFF, 16'h0);
        end

        // R10 R12: single-flag ops through the register
        set_cc(8'h00);
        reg_op("R10 set carry", OP_SETC, 1'b1);
        reg_op("R10 set overflow", OP_SETV, 1'b1);
        reg_op("R10 set I mask", OP_SETI, 1'b1);
        reg_op("R12 hold when write enable low", OP_CLRC, 1'b0);
        reg_op("R10 clear carry", OP_CLRC, 1'b1);
        reg_op("R10 clear overflow", OP_CLRV, 1'b1);
        reg_op("R10 clear I mask", OP_CLRI, 1'b1);
        set_cc(8'hEE);
        vec("R10 set carry result", OP_SETC, 1'b0, 16'h1234, 16'h0);
        vec("R10 clear I result", OP_CLRI, 1'b1, 16'hBEEF, 16'h0);

        // R11: flags to A and back
        set_cc(8'hC3);
        vec("R11 flags to A", OP_CC2A, 1'b0, 16'hFFFF, 16'h0);
        vec("R11 A to flags", OP_A2CC, 1'b0, 16'h9A5A, 16'h0);

        // R12: reset returns register to zero
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R12 reset clears flags", {16'h0, ccr_q}, 24'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule